// File: doc/BRIEF.md
# Multichannel DAC Code Register Bank with Write-Time Clamp

This block is the register file that sits in front of a bank of digital-to-analog converter channels. A host reaches it through a plain register bus: a write strobe with an address and a data word, and a read port that returns the addressed register one cycle later. Every channel holds two 13-bit codes in straight binary, from 0x0000 at the bottom of the range to 0x1FFF at full scale. The staging (buffer) code keeps what the host wrote. The live (active) code drives the converter and appears on a wide output bus.

A channel in immediate mode updates its live code on every data write. A channel in synchronous mode only stages the code, and a one-cycle load strobe later copies all staging codes into the live codes together. One broadcast address writes a single code into every channel selected by a broadcast mask. Each channel also has a 6-bit ceiling on the top six code bits. The ceiling is checked only when a code enters the live register, so a new ceiling never changes a code that is already live. It never touches the staging code.

Top module: `dac_regbank`

## Requirements
- R1: Reset (synchronous, active high) clears every staging code, live code, the broadcast mask, the synchronous-mode mask and rdata, and sets every channel ceiling to 0x3F.
- R2: A data write to channel c (address 0x00+c) in immediate mode (sync bit c = 0) places the code in both the staging and live registers of c at the next edge, and the live code appears at active_bus[13c+12:13c].
- R3: Any code entering a live register is clamped: if code[12:7] is greater than the channel ceiling L, the live register receives {L, 7'h7F}; otherwise it receives the code unchanged. A clamped result is never larger than the written code.
- R4: The staging register always keeps the written code without clamping.
- R5: Writing a ceiling (address 0x08+c, bits [5:0]) does not change any live code. Only codes written later are clamped against it.
- R6: A ceiling of 0x3F applies no limit, so code 0x1FFF reaches the live register unchanged.
- R7: A write to the broadcast address 0x18 stores the code in the staging register and the clamped code in the live register of every channel whose bit is set in the broadcast mask (address 0x19). Channels whose bit is clear keep both codes.
- R8: With sync bit c set (mask at address 0x1A), a data write to c leaves the live code of c unchanged. A load strobe copies every staging code into its live register, clamped against the ceiling in force during that cycle.
- R9: When a data write and a load strobe occur in the same cycle, an immediate-mode channel takes the written code. A synchronous-mode channel loads the staging code it held before that edge.
- R10: rdata shows, one cycle after the address is applied: the staging code at 0x00+c, the ceiling at 0x08+c, the live code at 0x10+c, the broadcast mask at 0x19, the sync mask at 0x1A, and zero at 0x18 and other global addresses. Writes to 0x10+c have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address (region in [4:3], channel or global index in [2:0]) |
| wdata | input | 16 | Write data |
| load | input | 1 | One-cycle strobe that copies staging codes into live codes |
| rdata | output | 16 | Registered read data for addr |
| active_bus | output | 104 | Live codes, channel c in bits [13c+12:13c] |

## Verification
The bench uses the default parameters: eight channels, 13-bit codes and 6-bit ceilings. With these values, full-scale code 0x1FFF, the top ceiling 0x3F and ceilings both above and below a written code can all be reached directly. The vectors mix immediate-mode and synchronous-mode channels and broadcast-enabled and broadcast-disabled channels. They include a ceiling lowered after a code went live, and write-plus-load collisions on both kinds of channel. Codes sit exactly at a ceiling and one step above it, so that an off-by-one in the comparison shows up.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

  typedef enum logic [1:0] {
    RGN_STAGE  = 2'd0,
    RGN_CEIL   = 2'd1,
    RGN_LIVE   = 2'd2,
    RGN_GLOBAL = 2'd3
  } region_e;

  localparam int GIDX_BCAST = 0;
  localparam int GIDX_BMASK = 1;
  localparam int GIDX_SMASK = 2;

endpackage

// File: rtl/dac_rb_decode.sv
module dac_rb_decode
  import dac_rb_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int NCH  = 1 << CH_W
) (
  input  logic              wr_en,
  input  logic [CH_W+1:0]   addr,
  output logic [NCH-1:0]    stage_we,
  output logic [NCH-1:0]    ceil_we,
  output logic              bcast_we,
  output logic              bmask_we,
  output logic              smask_we
);

  region_e         rgn;
  logic [CH_W-1:0] idx;

  assign rgn = region_e'(addr[CH_W+1:CH_W]);
  assign idx = addr[CH_W-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign stage_we[i] = wr_en && (rgn == RGN_STAGE) && (idx == CH_W'(i));
    assign ceil_we[i]  = wr_en && (rgn == RGN_CEIL)  && (idx == CH_W'(i));
  end

  assign bcast_we = wr_en && (rgn == RGN_GLOBAL) && (idx == CH_W'(GIDX_BCAST));
  assign bmask_we = wr_en && (rgn == RGN_GLOBAL) && (idx == CH_W'(GIDX_BMASK));
  assign smask_we = wr_en && (rgn == RGN_GLOBAL) && (idx == CH_W'(GIDX_SMASK));

endmodule

// File: rtl/dac_rb_channel.sv
module dac_rb_channel #(
  parameter int CODE_W = 13,
  parameter int LIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_we,
  input  logic              ceil_we,
  input  logic              bcast_hit,
  input  logic              sync_mode,
  input  logic              load,
  input  logic [CODE_W-1:0] wcode,
  input  logic [LIM_W-1:0]  wceil,
  output logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] live_q,
  output logic [LIM_W-1:0]  ceil_q
);

  localparam int LOW_W = CODE_W - LIM_W;

  function automatic logic [CODE_W-1:0] clamp_code(
    input logic [CODE_W-1:0] code,
    input logic [LIM_W-1:0]  lim
  );
    if (code[CODE_W-1 -: LIM_W] > lim)
      return {lim, {LOW_W{1'b1}}};
    return code;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ceil_q <= '1;
    end else if (ceil_we) begin
      ceil_q <= wceil;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (stage_we || bcast_hit) begin
      stage_q <= wcode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else if (stage_we && !sync_mode) begin
      live_q <= clamp_code(wcode, ceil_q);
    end else if (bcast_hit && !stage_we) begin
      live_q <= clamp_code(wcode, ceil_q);
    end else if (load) begin
      live_q <= clamp_code(stage_q, ceil_q);
    end
  end

endmodule

// File: rtl/dac_rb_readmux.sv
module dac_rb_readmux
  import dac_rb_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int NCH    = 1 << CH_W,
  parameter int CODE_W = 13,
  parameter int LIM_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic [CH_W+1:0]   addr,
  input  logic [CODE_W-1:0] stage_a [NCH],
  input  logic [CODE_W-1:0] live_a  [NCH],
  input  logic [LIM_W-1:0]  ceil_a  [NCH],
  input  logic [NCH-1:0]    bmask,
  input  logic [NCH-1:0]    smask,
  output logic [DATA_W-1:0] rd_next
);

  region_e         rgn;
  logic [CH_W-1:0] idx;

  assign rgn = region_e'(addr[CH_W+1:CH_W]);
  assign idx = addr[CH_W-1:0];

  always_comb begin
    rd_next = '0;
    unique case (rgn)
      RGN_STAGE: rd_next = DATA_W'(stage_a[idx]);
      RGN_CEIL:  rd_next = DATA_W'(ceil_a[idx]);
      RGN_LIVE:  rd_next = DATA_W'(live_a[idx]);
      RGN_GLOBAL: begin
        if (idx == CH_W'(GIDX_BMASK))      rd_next = DATA_W'(bmask);
        else if (idx == CH_W'(GIDX_SMASK)) rd_next = DATA_W'(smask);
        else                               rd_next = '0;
      end
      default: rd_next = '0;
    endcase
  end

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank #(
  parameter int CH_W   = 3,
  parameter int CODE_W = 13,
  parameter int LIM_W  = 6,
  parameter int DATA_W = 16,
  parameter int NCH    = 1 << CH_W,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic                    load,
  output logic [DATA_W-1:0]       rdata,
  output logic [NCH*CODE_W-1:0]   active_bus
);

  logic [NCH-1:0]    stage_we;
  logic [NCH-1:0]    ceil_we;
  logic              bcast_we;
  logic              bmask_we;
  logic              smask_we;
  logic [NCH-1:0]    bmask_q;
  logic [NCH-1:0]    smask_q;
  logic [CODE_W-1:0] stage_a [NCH];
  logic [CODE_W-1:0] live_a  [NCH];
  logic [LIM_W-1:0]  ceil_a  [NCH];
  logic [DATA_W-1:0] rd_next;

  dac_rb_decode #(
    .CH_W (CH_W),
    .NCH  (NCH)
  ) u_decode (
    .wr_en    (wr_en),
    .addr     (addr),
    .stage_we (stage_we),
    .ceil_we  (ceil_we),
    .bcast_we (bcast_we),
    .bmask_we (bmask_we),
    .smask_we (smask_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bmask_q <= '0;
      smask_q <= '0;
    end else begin
      if (bmask_we) bmask_q <= wdata[NCH-1:0];
      if (smask_we) smask_q <= wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_rb_channel #(
      .CODE_W (CODE_W),
      .LIM_W  (LIM_W)
    ) u_ch (
      .clk       (clk),
      .rst       (rst),
      .stage_we  (stage_we[i]),
      .ceil_we   (ceil_we[i]),
      .bcast_hit (bcast_we && bmask_q[i]),
      .sync_mode (smask_q[i]),
      .load      (load),
      .wcode     (wdata[CODE_W-1:0]),
      .wceil     (wdata[LIM_W-1:0]),
      .stage_q   (stage_a[i]),
      .live_q    (live_a[i]),
      .ceil_q    (ceil_a[i])
    );
    assign active_bus[i*CODE_W +: CODE_W] = live_a[i];
  end

  dac_rb_readmux #(
    .CH_W   (CH_W),
    .NCH    (NCH),
    .CODE_W (CODE_W),
    .LIM_W  (LIM_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .addr    (addr),
    .stage_a (stage_a),
    .live_a  (live_a),
    .ceil_a  (ceil_a),
    .bmask   (bmask_q),
    .smask   (smask_q),
    .rd_next (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int CH_W   = 3,
  parameter int CODE_W = 13,
  parameter int DATA_W = 16,
  parameter int NCH    = 1 << CH_W,
  parameter int ADDR_W = CH_W + 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [DATA_W-1:0]     wdata,
  input logic                  load,
  input logic [DATA_W-1:0]     rdata,
  input logic [NCH*CODE_W-1:0] active_bus
);

  logic [1:0]            rgn;
  logic [CH_W-1:0]       idx;
  logic [NCH-1:0]        smask_m;
  logic [CH_W-1:0]       idx_q;
  logic [CODE_W-1:0]     wcode_q;
  logic [NCH*CODE_W-1:0] bus_q;
  logic [CODE_W-1:0]     now_sel;
  logic [CODE_W-1:0]     old_sel;
  logic                  live_touch;

  assign rgn     = addr[ADDR_W-1:CH_W];
  assign idx     = addr[CH_W-1:0];
  assign now_sel = active_bus[idx_q*CODE_W +: CODE_W];
  assign old_sel = bus_q[idx_q*CODE_W +: CODE_W];
  assign live_touch = load || (wr_en && (rgn == 2'd0 || (rgn == 2'd3 && idx == '0)));

  always_ff @(posedge clk) begin
    idx_q   <= idx;
    wcode_q <= wdata[CODE_W-1:0];
    bus_q   <= active_bus;
    if (rst) smask_m <= '0;
    else if (wr_en && rgn == 2'd3 && idx == CH_W'(2)) smask_m <= wdata[NCH-1:0];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (active_bus == '0 && rdata == '0)); // R1

  AST_CLAMP_NOT_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rgn == 2'd0 && !smask_m[idx]) |=> (now_sel <= wcode_q)); // R3

  AST_CEIL_NO_RECLAMP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rgn == 2'd1 && !load) |=> $stable(active_bus)); // R5

  AST_SYNC_HOLDS_LIVE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rgn == 2'd0 && smask_m[idx] && !load) |=> (now_sel == old_sel)); // R8

  AST_LIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !live_touch |=> $stable(active_bus)); // R10

endmodule

bind dac_regbank dac_regbank_chk #(
  .CH_W   (CH_W),
  .CODE_W (CODE_W),
  .DATA_W (DATA_W),
  .NCH    (NCH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .load       (load),
  .rdata      (rdata),
  .active_bus (active_bus)
);

// File: tb/dac_regbank_test.sv
module dac_regbank_test;

  localparam int CODE_W = 13;
  localparam int NCH    = 8;
  localparam int NV     = 44;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  wr_en = 1'b0;
  logic [4:0]            addr = '0;
  logic [15:0]           wdata = '0;
  logic                  load = 1'b0;
  logic [15:0]           rdata;
  logic [NCH*CODE_W-1:0] active_bus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dac_regbank uut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .load       (load),
    .rdata      (rdata),
    .active_bus (active_bus)
  );

  always #4 clk = ~clk;

  // op: 0 write, 1 read-check, 2 load, 3 write+load, 4 live-bus check (channel in addr)
  // fields: {op[2:0], addr[7:0], data[15:0], req[3:0]}
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 8'h03, 16'h1FFF, 4'd6},
    {3'd4, 8'h03, 16'h1FFF, 4'd2},  // R2 R6
    {3'd1, 8'h13, 16'h1FFF, 4'd10}, // R10
    {3'd0, 8'h09, 16'h0020, 4'd3},
    {3'd0, 8'h01, 16'h1FFF, 4'd3},
    {3'd1, 8'h01, 16'h1FFF, 4'd4},  // R4
    {3'd1, 8'h11, 16'h107F, 4'd3},  // R3
    {3'd0, 8'h01, 16'h0800, 4'd3},
    {3'd1, 8'h11, 16'h0800, 4'd3},  // R3 below ceiling
    {3'd0, 8'h09, 16'h0005, 4'd5},
    {3'd1, 8'h11, 16'h0800, 4'd5},  // R5 no re-clamp
    {3'd1, 8'h09, 16'h0005, 4'd10},
    {3'd0, 8'h0A, 16'h0010, 4'd3},
    {3'd0, 8'h02, 16'h0800, 4'd3},
    {3'd1, 8'h12, 16'h0800, 4'd3},  // R3 exactly at ceiling
    {3'd0, 8'h02, 16'h0880, 4'd3},
    {3'd1, 8'h12, 16'h087F, 4'd3},  // R3 one step above
    {3'd0, 8'h19, 16'h0005, 4'd7},
    {3'd0, 8'h18, 16'h1234, 4'd7},
    {3'd1, 8'h10, 16'h1234, 4'd7},  // R7
    {3'd1, 8'h00, 16'h1234, 4'd7},
    {3'd1, 8'h12, 16'h087F, 4'd7},  // R7 clamped broadcast
    {3'd1, 8'h02, 16'h1234, 4'd7},
    {3'd1, 8'h13, 16'h1FFF, 4'd7},  // R7 disabled channel
    {3'd1, 8'h03, 16'h1FFF, 4'd7},
    {3'd1, 8'h18, 16'h0000, 4'd10},
    {3'd0, 8'h1A, 16'h0010, 4'd8},
    {3'd0, 8'h04, 16'h0ABC, 4'd8},
    {3'd4, 8'h04, 16'h0000, 4'd8},  // R8 live held
    {3'd1, 8'h04, 16'h0ABC, 4'd8},
    {3'd2, 8'h00, 16'h0000, 4'd8},
    {3'd4, 8'h04, 16'h0ABC, 4'd8},  // R8 load
    {3'd1, 8'h11, 16'h02FF, 4'd8},  // R8 clamp at load time
    {3'd1, 8'h12, 16'h087F, 4'd8},
    {3'd4, 8'h00, 16'h1234, 4'd8},
    {3'd0, 8'h04, 16'h0777, 4'd9},
    {3'd3, 8'h04, 16'h0555, 4'd9},
    {3'd4, 8'h04, 16'h0777, 4'd9},  // R9 sync channel loads old staging
    {3'd1, 8'h04, 16'h0555, 4'd9},
    {3'd3, 8'h00, 16'h0111, 4'd9},
    {3'd4, 8'h00, 16'h0111, 4'd9},  // R9 write wins
    {3'd4, 8'h04, 16'h0555, 4'd9},
    {3'd1, 8'h1A, 16'h0010, 4'd10},
    {3'd1, 8'h19, 16'h0005, 4'd10}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] live_of(input int ch);
    return 16'(active_bus[ch*CODE_W +: CODE_W]);
  endfunction

  task automatic read_chk(input int req, input logic [4:0] a, input logic [15:0] exp);
    addr = a;
    @(negedge clk);
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, rdata, 16'h0000);
    check(1, 16'(active_bus == '0), 16'h0001);
    rst = 1'b0;
    read_chk(1, 5'h0F, 16'h003F);
    read_chk(1, 5'h1A, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [4:0]  a;
      logic [15:0] d;
      int          rq;
      op = VEC[i][30:28];
      a  = VEC[i][24:20];
      d  = VEC[i][19:4];
      rq = int'(VEC[i][3:0]);
      case (op)
        3'd0: begin wr_en = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0; end
        3'd1: read_chk(rq, a, d);
        3'd2: begin load = 1; @(negedge clk); load = 0; end
        3'd3: begin wr_en = 1; load = 1; addr = a; wdata = d; @(negedge clk); wr_en = 0; load = 0; end
        default: check(rq, live_of(int'(a[2:0])), d);
      endcase
    end

    // R10 writes to the live region are ignored
    wr_en = 1; addr = 5'h13; wdata = 16'h0001; @(negedge clk); wr_en = 0;
    check(10, live_of(3), 16'h1FFF);

    // R1 reset mid-run restores defaults
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check(1, live_of(3), 16'h0000);
    read_chk(1, 5'h09, 16'h003F);
    read_chk(1, 5'h03, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule